// File: doc/BRIEF.md
# Serial Coefficient Memory Loader

This block fills a small memory of plane coefficients from a one-bit serial stream and then serves that memory as a read-only table. While the program request is high, every strobed serial bit goes into a word-wide shift register. When a full word has arrived, it is written to the location that a write pointer names through a one-hot decoder, and the pointer then steps on. When the program request drops, the block returns to run mode. In run mode the write path is closed, so no serial activity can change the table. The table is then read combinationally by plane index.

The decoder has more outputs than there are memory words. Words that land on the spare decoder lines write no memory. Instead they pick one test channel, reported as a one-hot selection for a monitoring multiplexer outside the block. A status output shows which mode the block is in.

Top module: `coef_loader`

## Requirements
- R1: After reset, `mode_prog` is 0, `test_sel` is all zero, and every plane reads as zero.
- R2: `mode_prog` equals the value `prog_en` had at the previous clock edge.
- R3: In program mode, a bit is taken only in cycles where `ser_valid` is 1, and the first bit taken becomes bit 24 of the word (MSB first). Field a sits in bits 24:16, field b in bits 15:7 and field c in bits 6:0. A word is complete on the edge that takes its 25th bit.
- R4: The write pointer is 0 at the start of every program session and rises by one for each completed word, so the k-th word of a session is stored in plane k (0 to 24).
- R5: Leaving program mode discards a partly shifted word. The first word of the next session is built only from bits taken in that session.
- R6: In run mode, `ser_valid` and `ser_bit` have no effect on any stored word or on `test_sel`.
- R7: A word completed while the pointer is 25 to 31 writes no plane and sets `test_sel` to the one-hot value with bit (pointer − 25) set. The pointer holds at 31 once it reaches 31. `test_sel` keeps its value until the next such word or a reset.
- R8: In run mode, `rd_word` shows the stored word of plane `rd_idx` in the same cycle, and shows 0 for `rd_idx` of 25 to 31. In program mode, `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Request for program mode |
| ser_valid | input | 1 | Strobe: `ser_bit` is taken this cycle |
| ser_bit | input | 1 | Serial coefficient data, MSB first |
| rd_idx | input | 5 | Plane index for the read port |
| mode_prog | output | 1 | Status: 1 in program mode, 0 in run mode |
| rd_word | output | 25 | Coefficient word of the indexed plane |
| test_sel | output | 7 | One-hot test channel selection |

## Verification
The hardest states to reach from the ports are the pointer at its ceiling and a session cut off in the middle of a word. A session cut off with bits still pending in the shift register looks, at the outputs, the same as a clean exit, until the next word lands. The bench therefore streams a full set of 25 planes and then nine more words. These drive the pointer through every test channel and hold it at 31. It also drops the program request ten bits into a word and then sends one full word in a new session. A stale bit would show up as a corrupted plane 0. A behavioural model built on a bit queue tracks every output on every clock.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  localparam int DEF_WORDS = 25;
  localparam int DEF_WBITS = 25;
  localparam int DEF_IDXW  = 5;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_PROG = 1'b1
  } mode_e;
endpackage

// File: rtl/cl_shifter.sv
module cl_shifter #(
  parameter int WBITS = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_prog,
  input  logic             ser_valid,
  input  logic             ser_bit,
  output logic             word_done,
  output logic [WBITS-1:0] word_out
);
  localparam int BCW  = $clog2(WBITS);
  localparam int LAST = WBITS - 1;

  logic [WBITS-2:0] shreg;
  logic [BCW-1:0]   bit_cnt;

  // A word is complete on the edge that takes its last bit.
  function automatic logic is_last(input logic [BCW-1:0] c);
    return c == BCW'(LAST);
  endfunction

  assign word_done = mode_prog & ser_valid & is_last(bit_cnt);
  assign word_out  = {shreg, ser_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!mode_prog) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (ser_valid) begin
      shreg   <= {shreg[WBITS-3:0], ser_bit};
      bit_cnt <= is_last(bit_cnt) ? '0 : bit_cnt + 1'b1;
    end
  end

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BCW'(LAST));
  // R5
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_prog |=> bit_cnt == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && !ser_valid) |=> $stable(bit_cnt));
endmodule

// File: rtl/cl_addr_dec.sv
module cl_addr_dec #(
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_prog,
  input  logic            word_done,
  output logic [IDXW-1:0] wr_ptr,
  output logic [(1<<IDXW)-1:0] dec_lines
);
  localparam int DECN = 1 << IDXW;
  localparam logic [IDXW-1:0] PTR_MAX = IDXW'(DECN - 1);

  function automatic logic [DECN-1:0] onehot_of(input logic [IDXW-1:0] p);
    logic [DECN-1:0] v;
    v = '0;
    for (int i = 0; i < DECN; i++) v[i] = (p == IDXW'(i));
    return v;
  endfunction

  assign dec_lines = onehot_of(wr_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else if (!mode_prog) wr_ptr <= '0;
    else if (word_done && wr_ptr != PTR_MAX) wr_ptr <= wr_ptr + 1'b1;
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && word_done && wr_ptr != PTR_MAX) |=> wr_ptr == $past(wr_ptr) + 1'b1);
  // R7
  ptr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && wr_ptr == PTR_MAX) |=> wr_ptr == PTR_MAX || !$past(mode_prog) || !mode_prog || wr_ptr == '0);
  // R4
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(dec_lines));
endmodule

// File: rtl/cl_mem_bank.sv
module cl_mem_bank #(
  parameter int WORDS = 25,
  parameter int WBITS = 25,
  parameter int IDXW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] wr_lines,
  input  logic [WBITS-1:0] wr_data,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [WBITS-1:0] rd_data
);
  logic [WBITS-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) mem[w] <= '0;
      else if (wr_lines[w]) mem[w] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++)
      if (rd_idx == IDXW'(w)) rd_data = mem[w];
  end

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_lines));
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int WORDS = DEF_WORDS,
  parameter int WBITS = DEF_WBITS,
  parameter int IDXW  = DEF_IDXW,
  localparam int DECN  = 1 << IDXW,
  localparam int TESTN = DECN - WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             ser_valid,
  input  logic             ser_bit,
  input  logic [IDXW-1:0]  rd_idx,
  output logic             mode_prog,
  output logic [WBITS-1:0] rd_word,
  output logic [TESTN-1:0] test_sel
);
  mode_e            mode_q;
  logic             word_done;
  logic [WBITS-1:0] word_data;
  logic [IDXW-1:0]  wr_ptr;
  logic [DECN-1:0]  dec_lines;
  logic [WORDS-1:0] mem_wr;
  logic [TESTN-1:0] test_hit;
  logic [WBITS-1:0] bank_data;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else mode_q <= prog_en ? MODE_PROG : MODE_RUN;
  end
  assign mode_prog = (mode_q == MODE_PROG);

  cl_shifter #(.WBITS(WBITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog),
    .ser_valid(ser_valid), .ser_bit(ser_bit),
    .word_done(word_done), .word_out(word_data)
  );

  cl_addr_dec #(.IDXW(IDXW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog),
    .word_done(word_done), .wr_ptr(wr_ptr), .dec_lines(dec_lines)
  );

  // Write strobes exist only on a completed word; in run mode none can fire.
  assign mem_wr   = word_done ? dec_lines[WORDS-1:0]    : '0;
  assign test_hit = word_done ? dec_lines[DECN-1:WORDS] : '0;

  cl_mem_bank #(.WORDS(WORDS), .WBITS(WBITS), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_lines(mem_wr), .wr_data(word_data),
    .rd_idx(rd_idx), .rd_data(bank_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) test_sel <= '0;
    else if (|test_hit) test_sel <= test_hit;
  end

  assign rd_word = mode_prog ? '0 : bank_data;

  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_prog == $past(prog_en));
  // R6
  run_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_prog |-> (mem_wr == '0 && test_hit == '0));
  // R7
  test_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(test_sel));
  // R7
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_prog |=> $stable(test_sel));
  // R8
  prog_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_prog |-> rd_word == '0);
endmodule

// File: tb/sim_coef_loader.sv
module sim_coef_loader;
  localparam int CLK_P = 10;
  localparam int NW = 25;
  localparam int NT = 7;

  logic clk = 0, rst_n = 0, prog_en = 0, ser_valid = 0, ser_bit = 0;
  logic [4:0]  rd_idx = 0;
  logic        mode_prog;
  logic [24:0] rd_word;
  logic [6:0]  test_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  coef_loader u0 (.clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .rd_idx(rd_idx),
    .mode_prog(mode_prog), .rd_word(rd_word), .test_sel(test_sel));

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  logic [24:0] m_mem [NW];
  logic [6:0]  m_test;
  bit          m_mode;
  int          m_ptr;
  bit          m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = '0;
      m_test = '0; m_mode = 0; m_ptr = 0; m_q.delete();
    end else begin
      if (!m_mode) begin
        m_q.delete(); m_ptr = 0;
      end else if (ser_valid) begin
        m_q.push_back(ser_bit);
        if (m_q.size() == 25) begin
          logic [24:0] w;
          w = '0;
          foreach (m_q[i]) w = {w[23:0], m_q[i]};
          if (m_ptr < NW) m_mem[m_ptr] = w;
          else m_test = 7'(1 << (m_ptr - NW));
          if (m_ptr < 31) m_ptr++;
          m_q.delete();
        end
      end
      m_mode = prog_en;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, sampled 3 time units after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [24:0] exp_rd;
      exp_rd = (m_mode || rd_idx >= 5'(NW)) ? 25'd0 : m_mem[rd_idx];
      chk("R2 mode", 32'(mode_prog), 32'(m_mode));
      chk("R7 test_sel", 32'(test_sel), 32'(m_test));
      chk("R8 rd_word", 32'(rd_word), 32'(exp_rd));
    end
  end

  function automatic logic [24:0] pat(input int k);
    return 25'((k * 32'h0A3B5 + 32'h13579) ^ 32'h1F0F0F3);
  endfunction

  task automatic send_word(input logic [24:0] w, input bit gaps);
    for (int i = 24; i >= 0; i--) begin
      @(negedge clk); ser_valid = 1; ser_bit = w[i];
      if (gaps && (i % 5 == 0)) begin
        @(negedge clk); ser_valid = 0; ser_bit = ~w[i];
      end
    end
    @(negedge clk); ser_valid = 0; ser_bit = 0;
  endtask

  task automatic set_prog(input bit v);
    @(negedge clk); prog_en = v;
    @(negedge clk);
  endtask

  task automatic read_plane(input int idx, output logic [24:0] w);
    @(negedge clk); rd_idx = 5'(idx); #1 w = rd_word;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [24:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mode", 32'(mode_prog), 0);
    chk("R1 test_sel", 32'(test_sel), 0);
    read_plane(7, w); chk("R1 plane7", 32'(w), 0);

    // R6: serial activity in run mode
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); ser_valid = 1; ser_bit = i[0];
    end
    @(negedge clk); ser_valid = 0;
    read_plane(0, w); chk("R6 plane0", 32'(w), 0);
    chk("R6 test_sel", 32'(test_sel), 0);

    // R2/R3/R4: full load, some words with idle gaps
    @(negedge clk); prog_en = 1;
    #1 chk("R2 before edge", 32'(mode_prog), 0);
    @(negedge clk); chk("R2 after edge", 32'(mode_prog), 1);
    for (int k = 0; k < NW; k++) send_word(pat(k), k % 3 == 1);
    set_prog(0);
    for (int k = 0; k < NW; k++) begin
      read_plane(k, w); chk("R4 plane", 32'(w), 32'(pat(k)));
    end
    read_plane(1, w); chk("R3 gapped word", 32'(w), 32'(pat(1)));
    read_plane(27, w); chk("R8 idx27", 32'(w), 0);

    // R4 restart and R5 partial discard
    set_prog(1);
    send_word(25'h1ABCDEF, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ser_valid = 1; ser_bit = 1;
    end
    @(negedge clk); ser_valid = 0;
    set_prog(0);
    read_plane(0, w); chk("R4 restart plane0", 32'(w), 32'h1ABCDEF);
    read_plane(1, w); chk("R5 plane1 untouched", 32'(w), 32'(pat(1)));
    set_prog(1);
    send_word(25'h0000123, 0);
    set_prog(0);
    read_plane(0, w); chk("R5 fresh word", 32'(w), 32'h0000123);
    read_plane(1, w); chk("R5 plane1 still", 32'(w), 32'(pat(1)));

    // R7: pointer into test channels and ceiling
    set_prog(1);
    for (int k = 0; k < NW; k++) send_word(pat(k + 40), 0);
    for (int k = 0; k < 3; k++) send_word(25'h1FFFFFF, 0);
    @(negedge clk); chk("R7 chan2", 32'(test_sel), 32'h04);
    for (int k = 0; k < 6; k++) send_word(25'h0F0F0F0, 0);
    @(negedge clk); chk("R7 ceiling", 32'(test_sel), 32'h40);
    set_prog(0);
    read_plane(24, w); chk("R7 plane24 kept", 32'(w), 32'(pat(64)));
    read_plane(0, w); chk("R7 plane0 kept", 32'(w), 32'(pat(40)));
    chk("R7 hold", 32'(test_sel), 32'h40);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule